// File: doc/BRIEF.md
# Pipelined DES Block Encryptor

This block enciphers one 64-bit block per clock under the Data Encryption Standard. The cipher is laid out as sixteen dedicated round stages with a register bank between each pair. The key schedule is carried down the pipeline next to the data, so each block can use its own key. A block and a key presented together leave the pipeline sixteen cycles later as a ciphertext, paired with the key that produced it. This suits a key-search engine that offers a new candidate key on every cycle.

Each stage registers the two 32-bit data halves and the two 28-bit key halves. Each stage holds exactly one round of logic: key-half rotation, round-key selection, expansion, key mixing, substitution and permutation. The bit shuffles are wiring only. Each of the eight substitution boxes is split per output bit into four 4-input functions of the middle input bits, and a 4:1 multiplexer steered by the two outer bits picks one of them. The initial permutation is applied before the first stage. The half swap and the final permutation are applied after the last stage.

Top module: `des_pipe_core`

## Requirements
- R1: For every accepted block, `out_text` equals the DES encryption of `in_text` under the key on `in_key`. Bit 63 of each 64-bit bus is DES bit 1.
- R2: `out_valid` is high in exactly the cycle 16 clocks after the cycle in which `in_valid` was sampled high. The core accepts one block every clock, with no stall.
- R3: Blocks on consecutive cycles may carry different keys, and each result depends only on its own key and plaintext.
- R4: While `out_valid` is high, `out_key` equals the `in_key` value that entered with that block. The key format is the 64-bit key with the low bit of each byte removed: byte b (b=0 is the most significant) supplies its upper seven bits to `in_key[55-7b -: 7]`.
- R5: Out of reset, and whenever no block was accepted 16 cycles earlier, `out_valid` is low.
- R6: A synchronous active-high `rst` clears every in-flight valid marker. No block accepted before the reset ever raises `out_valid`.
- R7: Complementing both the key and the plaintext yields the bitwise complement of the original ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | A block is presented this cycle |
| in_text | input | 64 | Plaintext block |
| in_key | input | 56 | Key with parity bits already removed |
| out_valid | output | 1 | `out_text` and `out_key` carry a result |
| out_text | output | 64 | Ciphertext block |
| out_key | output | 56 | Key that produced `out_text` |

## Verification
A wrong entry in any substitution leaf, a wrong rotation amount in one stage, or a miswired permutation corrupts every block that passes through. The damage shows on `out_text` exactly sixteen cycles after the affected block entered. It shows as a mismatch against the known-answer vectors, or as a broken complement relation between paired results. A fault in the carried key halves also shows on `out_key` in that same cycle. A slip in the valid chain shows as an early, late, missing or spurious `out_valid` at the first block it touches.

// File: rtl/des_pipe_pkg.sv
package des_pipe_pkg;

  localparam int BLK_W   = 64;
  localparam int HALF_W  = BLK_W / 2;
  localparam int KEY_W   = 56;
  localparam int KH_W    = KEY_W / 2;
  localparam int RK_W    = 48;
  localparam int ROUNDS  = 16;
  localparam int NBOX    = 8;
  localparam int BOX_IN  = RK_W / NBOX;
  localparam int BOX_OUT = HALF_W / NBOX;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [KH_W-1:0]   khalf_t;

  // Round-output bit order of the substitution results
  localparam logic [32*8-1:0] PERM_TBL = {
    8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
    8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
    8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
    8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25};

  // Key bits (64-bit numbering) feeding the two 28-bit halves
  localparam logic [56*8-1:0] KSEL1_TBL = {
    8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,
    8'd1,  8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18,
    8'd10, 8'd2,  8'd59, 8'd51, 8'd43, 8'd35, 8'd27,
    8'd19, 8'd11, 8'd3,  8'd60, 8'd52, 8'd44, 8'd36,
    8'd63, 8'd55, 8'd47, 8'd39, 8'd31, 8'd23, 8'd15,
    8'd7,  8'd62, 8'd54, 8'd46, 8'd38, 8'd30, 8'd22,
    8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37, 8'd29,
    8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4};

  // Round-key bits taken from the rotated halves
  localparam logic [48*8-1:0] KSEL2_TBL = {
    8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,
    8'd3,  8'd28, 8'd15, 8'd6,  8'd21, 8'd10,
    8'd23, 8'd19, 8'd12, 8'd4,  8'd26, 8'd8,
    8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
    8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55,
    8'd30, 8'd40, 8'd51, 8'd45, 8'd33, 8'd48,
    8'd44, 8'd49, 8'd39, 8'd56, 8'd34, 8'd53,
    8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32};

  function automatic int tbl8(input logic [447:0] t, input int n, input int i);
    return int'(t[(n-1-i)*8 +: 8]);
  endfunction

  // Source bit (1-based) of the entry shuffle for output position i
  function automatic int ip_src(input int i);
    int r;
    int c;
    r = i / 8;
    c = i % 8;
    return ((r < 4) ? (58 + 2*r) : (57 + 2*(r-4))) - 8*c;
  endfunction

  function automatic logic [BLK_W-1:0] ip_fn(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] fp_fn(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic logic [RK_W-1:0] expand_fn(input half_t x);
    logic [RK_W-1:0] y;
    y = '0;
    for (int g = 0; g < NBOX; g++)
      for (int j = 0; j < BOX_IN; j++)
        y[RK_W-1-(BOX_IN*g+j)] = x[HALF_W-1-((BOX_OUT*g+j+HALF_W-1) % HALF_W)];
    return y;
  endfunction

  function automatic half_t perm_fn(input half_t x);
    half_t y;
    y = '0;
    for (int i = 0; i < HALF_W; i++)
      y[HALF_W-1-i] = x[HALF_W-tbl8({192'b0, PERM_TBL}, 32, i)];
    return y;
  endfunction

  // Compact (parity-free) index of a 64-bit key position
  function automatic int compact(input int p);
    return p - p/8;
  endfunction

  function automatic logic [KEY_W-1:0] ksel1_fn(input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] y;
    y = '0;
    for (int i = 0; i < KEY_W; i++)
      y[KEY_W-1-i] = k[KEY_W-compact(tbl8(KSEL1_TBL, 56, i))];
    return y;
  endfunction

  function automatic logic [KEY_W-1:0] ksel1_inv_fn(input logic [KEY_W-1:0] cd);
    logic [KEY_W-1:0] y;
    y = '0;
    for (int i = 0; i < KEY_W; i++)
      y[KEY_W-compact(tbl8(KSEL1_TBL, 56, i))] = cd[KEY_W-1-i];
    return y;
  endfunction

  function automatic logic [RK_W-1:0] ksel2_fn(input logic [KEY_W-1:0] cd);
    logic [RK_W-1:0] y;
    y = '0;
    for (int i = 0; i < RK_W; i++)
      y[RK_W-1-i] = cd[KEY_W-tbl8({64'b0, KSEL2_TBL}, 48, i)];
    return y;
  endfunction

  // Rounds 1, 2, 9 and 16 rotate by one place, all others by two
  function automatic int rot_amt(input int rnd);
    return (rnd == 0 || rnd == 1 || rnd == 8 || rnd == ROUNDS-1) ? 1 : 2;
  endfunction

  function automatic khalf_t rotl_fn(input khalf_t x, input int n);
    return (n == 1) ? {x[KH_W-2:0], x[KH_W-1]} : {x[KH_W-3:0], x[KH_W-1:KH_W-2]};
  endfunction

  // Row r of box s, column c held in nibble c counted from the top
  function automatic logic [63:0] box_row(input int s, input int r);
    case (s*4 + r)
      0:  return 64'hE4D12FB83A6C5907;  1:  return 64'h0F74E2D1A6CB9538;
      2:  return 64'h41E8D62BFC973A50;  3:  return 64'hFC8249175B3EA06D;
      4:  return 64'hF18E6B34972DC05A;  5:  return 64'h3D47F28EC01A69B5;
      6:  return 64'h0E7BA4D158C6932F;  7:  return 64'hD8A13F42B67C05E9;
      8:  return 64'hA09E63F51DC7B428;  9:  return 64'hD709346A285ECBF1;
      10: return 64'hD6498F30B12C5AE7;  11: return 64'h1AD069874FE3B52C;
      12: return 64'h7DE3069A1285BC4F;  13: return 64'hD8B56F03472C1AE9;
      14: return 64'hA690CB7DF13E5284;  15: return 64'h3F06A1D8945BC72E;
      16: return 64'h2C417AB6853FD0E9;  17: return 64'hEB2C47D150FA3986;
      18: return 64'h421BAD78F9C5630E;  19: return 64'hB8C71E2D6F09A453;
      20: return 64'hC1AF92680D34E75B;  21: return 64'hAF427C9561DE0B38;
      22: return 64'h9EF528C3704A1DB6;  23: return 64'h432C95FABE17608D;
      24: return 64'h4B2EF08D3C975A61;  25: return 64'hD0B7491AE35C2F86;
      26: return 64'h14BDC37EAF680592;  27: return 64'h6BD814A7950FE23C;
      28: return 64'hD2846FB1A93E50C7;  29: return 64'h1FD8A374C56B0E92;
      30: return 64'h7B419CE206ADF358;  default: return 64'h21E74A8DFC90356B;
    endcase
  endfunction

  // One 4-input leaf: output bit b of box s in row r, as a function of the middle bits
  function automatic logic leaf_bit(input int s, input int r, input int b,
                                    input logic [3:0] col);
    logic [63:0] row;
    logic [3:0]  nib;
    row = box_row(s, r);
    nib = row[(15 - int'(col))*4 +: 4];
    return nib[b];
  endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
  import des_pipe_pkg::*;
#(
  parameter int BOX_ID = 0
) (
  input  logic [BOX_IN-1:0]  six_i,
  output logic [BOX_OUT-1:0] nib_o
);

  localparam int NLEG = 4;

  logic [1:0] row_sel;
  logic [3:0] mid;

  assign row_sel = {six_i[BOX_IN-1], six_i[0]};
  assign mid     = six_i[BOX_IN-2:1];

  for (genvar b = 0; b < BOX_OUT; b++) begin : g_bit
    logic [NLEG-1:0] leg;
    for (genvar r = 0; r < NLEG; r++) begin : g_leg
      assign leg[r] = leaf_bit(BOX_ID, r, b, mid);
    end
    assign nib_o[b] = leg[row_sel];
  end

endmodule

// File: rtl/des_round_stage.sv
module des_round_stage
  import des_pipe_pkg::*;
#(
  parameter int RND = 0
) (
  input  logic   clk,
  input  half_t  l_i,
  input  half_t  r_i,
  input  khalf_t c_i,
  input  khalf_t d_i,
  output half_t  l_q,
  output half_t  r_q,
  output khalf_t c_q,
  output khalf_t d_q
);

  localparam int SHIFT = rot_amt(RND);

  khalf_t          c_rot, d_rot;
  logic [RK_W-1:0] round_key;
  logic [RK_W-1:0] mixed;
  half_t           box_out;
  half_t           f_out;

  assign c_rot     = rotl_fn(c_i, SHIFT);
  assign d_rot     = rotl_fn(d_i, SHIFT);
  assign round_key = ksel2_fn({c_rot, d_rot});
  assign mixed     = expand_fn(r_i) ^ round_key;

  for (genvar s = 0; s < NBOX; s++) begin : g_box
    des_sbox #(.BOX_ID(s)) u_box (
      .six_i (mixed[RK_W-1-BOX_IN*s -: BOX_IN]),
      .nib_o (box_out[HALF_W-1-BOX_OUT*s -: BOX_OUT])
    );
  end

  assign f_out = perm_fn(box_out);

  always_ff @(posedge clk) begin
    l_q <= r_i;
    r_q <= l_i ^ f_out;
    c_q <= c_rot;
    d_q <= d_rot;
  end

endmodule

// File: rtl/des_pipe_core.sv
module des_pipe_core
  import des_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  in_text,
  input  logic [KEY_W-1:0]  in_key,
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_text,
  output logic [KEY_W-1:0]  out_key
);

  half_t  l_s [ROUNDS+1];
  half_t  r_s [ROUNDS+1];
  khalf_t c_s [ROUNDS+1];
  khalf_t d_s [ROUNDS+1];

  logic [BLK_W-1:0]  ip_blk;
  logic [KEY_W-1:0]  cd_in;
  logic [ROUNDS-1:0] vld_q;

  assign ip_blk = ip_fn(in_text);
  assign cd_in  = ksel1_fn(in_key);
  assign l_s[0] = ip_blk[BLK_W-1:HALF_W];
  assign r_s[0] = ip_blk[HALF_W-1:0];
  assign c_s[0] = cd_in[KEY_W-1:KH_W];
  assign d_s[0] = cd_in[KH_W-1:0];

  for (genvar k = 0; k < ROUNDS; k++) begin : g_stage
    des_round_stage #(.RND(k)) u_stage (
      .clk (clk),
      .l_i (l_s[k]),
      .r_i (r_s[k]),
      .c_i (c_s[k]),
      .d_i (d_s[k]),
      .l_q (l_s[k+1]),
      .r_q (r_s[k+1]),
      .c_q (c_s[k+1]),
      .d_q (d_s[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[ROUNDS-2:0], in_valid};
  end

  // Rotations total 28 places, so the last key halves are back in selected order
  assign out_valid = vld_q[ROUNDS-1];
  assign out_text  = fp_fn({r_s[ROUNDS], l_s[ROUNDS]});
  assign out_key   = ksel1_inv_fn({c_s[ROUNDS], d_s[ROUNDS]});

endmodule

// File: rtl/des_pipe_chk.sv
module des_pipe_chk
  import des_pipe_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [KEY_W-1:0] in_key,
  input logic             out_valid,
  input logic [BLK_W-1:0] out_text,
  input logic [KEY_W-1:0] out_key
);

  localparam int CW = $clog2(ROUNDS + 1);

  logic [CW-1:0] clean_cyc = '0;
  logic          filled;

  always_ff @(posedge clk) begin
    if (rst)                          clean_cyc <= '0;
    else if (clean_cyc != CW'(ROUNDS)) clean_cyc <= clean_cyc + 1'b1;
  end

  assign filled = (clean_cyc == CW'(ROUNDS));

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    filled |-> (out_valid == $past(in_valid, 16)));

  // R4
  key_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (filled && out_valid) |-> (out_key == $past(in_key, 16)));

  // R6
  reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R5
  no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (clean_cyc == '0) |-> !out_valid);

  // R1
  text_known_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_text));

endmodule

bind des_pipe_core des_pipe_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_key    (in_key),
  .out_valid (out_valid),
  .out_text  (out_text),
  .out_key   (out_key)
);

// File: tb/tb_des_pipe_core.sv
`timescale 1ns/1ps
module tb_des_pipe_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_text = '0;
  logic [55:0] in_key = '0;
  logic        out_valid;
  logic [63:0] out_text;
  logic [55:0] out_key;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [63:0] ct;
    logic [55:0] key;
    int          due;
    bit          cpl;
  } exp_t;
  exp_t sb[$];

  logic [63:0] vk [7];
  logic [63:0] vp [7];
  logic [63:0] vc [7];

  des_pipe_core dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_text (in_text),
    .in_key (in_key), .out_valid (out_valid), .out_text (out_text), .out_key (out_key)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [55:0] strip(input logic [63:0] k);
    logic [55:0] y;
    for (int b = 0; b < 8; b++) y[55-7*b -: 7] = k[63-8*b -: 7];
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic send(input logic [63:0] k64, input logic [63:0] pt,
                      input logic [63:0] ct, input bit cpl);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_text  = pt;
    in_key   = strip(k64);
    e.ct = ct; e.key = strip(k64); e.due = cyc + 16; e.cpl = cpl;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_text  = 64'h0;
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R5 unexpected out_valid", 64'(out_valid), 64'h0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.due == cyc, "R2 latency", 64'(cyc), 64'(e.due));
            chk(out_text == e.ct, e.cpl ? "R7 complement ciphertext" : "R1 R3 ciphertext",
                out_text, e.ct);
            chk(out_key == e.key, "R4 key out", 64'(out_key), 64'(e.key));
          end
        end else if (sb.size() != 0 && sb[0].due <= cyc) begin
          chk(1'b0, "R2 missing out_valid", 64'(out_valid), 64'h1);
          void'(sb.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vk[0] = 64'h133457799BBCDFF1; vp[0] = 64'h0123456789ABCDEF; vc[0] = 64'h85E813540F0AB405;
    vk[1] = 64'h0E329232EA6D0D73; vp[1] = 64'h8787878787878787; vc[1] = 64'h0000000000000000;
    vk[2] = 64'h0101010101010101; vp[2] = 64'h8000000000000000; vc[2] = 64'h95F8A5E5DD31D900;
    vk[3] = 64'h0101010101010101; vp[3] = 64'h95F8A5E5DD31D900; vc[3] = 64'h8000000000000000;
    vk[4] = 64'h0123456789ABCDEF; vp[4] = 64'h4E6F772069732074; vc[4] = 64'h3FA40E8A984D4815;
    vk[5] = 64'h0000000000000000; vp[5] = 64'h0000000000000000; vc[5] = 64'h8CA64DE9C1B123A7;
    vk[6] = 64'hFFFFFFFFFFFFFFFF; vp[6] = 64'hFFFFFFFFFFFFFFFF; vc[6] = 64'h7359B2163E4EDC58;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5 reset state", 64'(out_valid), 64'h0);
    rst = 1'b0;
    idle(2);
    chk(out_valid == 1'b0, "R5 idle after reset", 64'(out_valid), 64'h0);

    // R1: isolated blocks with gaps
    for (int i = 0; i < 7; i++) begin
      send(vk[i], vp[i], vc[i], 1'b0);
      idle(3);
    end
    idle(20);

    // R3 and R7: back-to-back, a different key every cycle
    for (int i = 0; i < 7; i++) begin
      send(vk[i], vp[i], vc[i], 1'b0);
      send(~vk[i], ~vp[i], ~vc[i], 1'b1);
    end
    idle(20);

    // R6: reset while blocks are in flight
    for (int i = 0; i < 4; i++) send(vk[i], vp[i], vc[i], 1'b0);
    idle(4);
    @(negedge clk);
    sb.delete();
    rst = 1'b1;
    in_valid = 1'b0;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 flushed block reappeared", 64'(out_valid), 64'h0);
    end

    // Mixed spacing after the flush
    for (int i = 0; i < 7; i++) begin
      send(vk[6-i], vp[6-i], vc[6-i], 1'b0);
      if (i % 2 == 0) idle(1);
    end
    idle(24);
    chk(sb.size() == 0, "R2 all results drained", 64'(sb.size()), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule